// File: doc/BRIEF.md
# Speed-Ranked Free Block Allocator

This block keeps, for every flash chip behind a controller, a list of that chip's erased blocks ranked by measured program speed, fastest first. A write that has been split into single-chip pieces asks it for a target block. The request carries the chip index and the number of requests now pending on that chip. When the chip is contended, the piece gets the fastest usable block so the work queued behind it drains sooner. When the chip is idle, the piece gets the slowest usable block, which keeps the fast blocks for the moments that need them.

Three maintenance commands keep the lists current. One retires a block whose pages are all programmed. One returns an erased block to service after reclaim. One lowers a block's speed code after a new measurement and moves the block down the ranking. The ranking is held per chip in a small array. A demoted entry sinks through the array one position per clock cycle. Commands are taken one at a time: a command is accepted while `busy` is low, and it finishes with a single-cycle response.

Top module: `speed_rank_alloc`

## Requirements
- R1: After reset, every chip's list holds all its block IDs in ascending order (rank 0 is block 0). Every entry is usable and carries the all-ones speed code. `busy` and `rsp_valid` are low.
- R2: A command presented with `cmd_valid` while `busy` is low is accepted. `busy` is high from the next cycle until the response. `cmd_valid` while `busy` is high is ignored.
- R3: Each command produces exactly one response: `rsp_valid` high for one cycle, with `busy` low in that cycle. Commands other than a successful demotion respond one cycle after acceptance.
- R4: The allocate command (`cmd_op`=2'b00) with `cmd_pending` greater than 1 returns the highest-ranked usable block of chip `cmd_chip`.
- R5: The allocate command with `cmd_pending` of 0 or 1 returns the lowest-ranked usable block of that chip.
- R6: An allocate command on a chip with no usable block responds with `rsp_none`=1 and grants no block.
- R7: The retire command (`cmd_op`=2'b01) makes `cmd_block` of `cmd_chip` unusable, so no later allocation returns it until it is restored.
- R8: The restore command (`cmd_op`=2'b10) makes the block usable again at its current rank.
- R9: The demote command (`cmd_op`=2'b11) with a `cmd_speed` strictly below the block's code stores the new code. The block moves behind every later entry whose code is greater than or equal to the new code, one position per cycle. The response comes k+2 cycles after acceptance, where k is the number of positions moved, and echoes the block.
- R10: A demote command whose code is not strictly lower responds with `rsp_none`=1 one cycle after acceptance and leaves the ranking unchanged.
- R11: Commands on one chip never change the result of allocations on another chip.
- R12: Whenever the block is idle, every chip's list is ordered by non-increasing speed code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | 00 allocate, 01 retire, 10 restore, 11 demote |
| cmd_chip | input | CHIP_W | Target chip index |
| cmd_block | input | BLK_W | Block ID for retire, restore and demote |
| cmd_speed | input | SPD_W | New speed code for demote |
| cmd_pending | input | PEND_W | Requests pending on the target chip (allocate) |
| busy | output | 1 | Command in progress; new commands ignored |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_block | output | BLK_W | Granted block (allocate) or echoed block |
| rsp_none | output | 1 | No block granted, or demotion rejected |

## Verification
The hardest state to reach is a list where several demoted blocks share or interleave speed codes. Only in that state does a tie decide where a sinking entry stops, and only there is the response latency something other than the full array length. The bench first demotes blocks of one chip one after another with equal and differing codes, so that later demotions must stop behind earlier ones. It then runs a long pseudo-random mix of all four commands against a reference list model, which checks the granted block and the exact response cycle. One demotion has a command injected while the entry is still sinking, and a later allocation on the untouched chip shows that the injected command had no effect.

// File: rtl/sra_pkg.sv
// Shared encodings for the speed-ranked allocator.
// Assumes: command encoding is fixed by the port contract.
package sra_pkg;
    typedef enum logic [1:0] {
        CMD_ALLOC  = 2'b00,
        CMD_RETIRE = 2'b01,
        CMD_RESTORE = 2'b10,
        CMD_DEMOTE = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        LOP_SETV,
        LOP_CLRV,
        LOP_SPEED,
        LOP_SWAP
    } list_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_SHIFT
    } fsm_e;
endpackage

// File: rtl/sra_chip_list.sv
// Ranked entry storage for one chip: block ID, speed code and usable flag per rank.
// Performs one primitive edit per cycle: set flag, clear flag, write speed,
// or swap a rank with the one below it.
// Assumes: the controller never requests a swap at the last rank.
module sra_chip_list
    import sra_pkg::*;
#(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = 3,
    parameter int SPD_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          op_en,
    input  list_op_e                      op_kind,
    input  logic [BLK_W-1:0]              op_idx,
    input  logic [SPD_W-1:0]              op_spd,
    output logic [BLOCKS-1:0][BLK_W-1:0]  ids,
    output logic [BLOCKS-1:0][SPD_W-1:0]  spds,
    output logic [BLOCKS-1:0]             vlds
);
    localparam logic [BLK_W-1:0] LAST = BLK_W'(BLOCKS - 1);

    logic [BLK_W-1:0] below;

    // Index of the rank just below the edited one.
    always_comb begin
        below = op_idx + 1'b1;
    end

    // Entry storage: reset to ID order at top speed, then apply one edit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) begin
                ids[i]  <= BLK_W'(i);
                spds[i] <= '1;
                vlds[i] <= 1'b1;
            end
        end else if (op_en) begin
            case (op_kind)
                LOP_SETV:  vlds[op_idx] <= 1'b1;
                LOP_CLRV:  vlds[op_idx] <= 1'b0;
                LOP_SPEED: spds[op_idx] <= op_spd;
                LOP_SWAP: begin
                    if (op_idx != LAST) begin
                        ids[op_idx]  <= ids[below];
                        ids[below]   <= ids[op_idx];
                        spds[op_idx] <= spds[below];
                        spds[below]  <= spds[op_idx];
                        vlds[op_idx] <= vlds[below];
                        vlds[below]  <= vlds[op_idx];
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sra_rank_find.sv
// Combinational search over one chip's ranked list: best usable rank,
// worst usable rank, and the rank holding a given block ID.
// Assumes: block IDs in the list are unique.
module sra_rank_find #(
    parameter int BLOCKS = 8,
    parameter int BLK_W  = 3
) (
    input  logic [BLOCKS-1:0][BLK_W-1:0] ids,
    input  logic [BLOCKS-1:0]            vlds,
    input  logic [BLK_W-1:0]             key,
    output logic [BLK_W-1:0]             top_idx,
    output logic                         top_ok,
    output logic [BLK_W-1:0]             bot_idx,
    output logic                         bot_ok,
    output logic [BLK_W-1:0]             hit_idx,
    output logic                         hit_ok
);
    // Lowest usable rank: scanning downward so the smallest index wins.
    always_comb begin
        top_idx = '0;
        top_ok  = 1'b0;
        for (int i = BLOCKS - 1; i >= 0; i--) begin
            if (vlds[i]) begin
                top_idx = BLK_W'(i);
                top_ok  = 1'b1;
            end
        end
    end

    // Highest usable rank: scanning upward so the largest index wins.
    always_comb begin
        bot_idx = '0;
        bot_ok  = 1'b0;
        for (int i = 0; i < BLOCKS; i++) begin
            if (vlds[i]) begin
                bot_idx = BLK_W'(i);
                bot_ok  = 1'b1;
            end
        end
    end

    // Rank of the requested block ID.
    always_comb begin
        hit_idx = '0;
        hit_ok  = 1'b0;
        for (int i = 0; i < BLOCKS; i++) begin
            if (ids[i] == key) begin
                hit_idx = BLK_W'(i);
                hit_ok  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/speed_rank_alloc.sv
// Speed-ranked free block allocator. One ranked list per chip; a command
// controller serves allocate, retire, restore and demote one at a time.
// Demotion sinks the entry one rank per cycle to keep the list sorted.
// Assumes: cmd_chip < CHIPS; responses are consumed as single-cycle strobes.
module speed_rank_alloc
    import sra_pkg::*;
#(
    parameter int  CHIPS  = 4,
    parameter int  BLOCKS = 8,
    parameter int  SPD_W  = 4,
    parameter int  PEND_W = 4,
    localparam int CHIP_W = (CHIPS > 1) ? $clog2(CHIPS) : 1,
    localparam int BLK_W  = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [CHIP_W-1:0] cmd_chip,
    input  logic [BLK_W-1:0]  cmd_block,
    input  logic [SPD_W-1:0]  cmd_speed,
    input  logic [PEND_W-1:0] cmd_pending,
    output logic              busy,
    output logic              rsp_valid,
    output logic [BLK_W-1:0]  rsp_block,
    output logic              rsp_none
);
    localparam logic [BLK_W-1:0] LAST = BLK_W'(BLOCKS - 1);

    fsm_e              state;
    cmd_op_e           q_op;
    logic [CHIP_W-1:0] q_chip;
    logic [BLK_W-1:0]  q_blk;
    logic [SPD_W-1:0]  q_spd;
    logic              q_fast;
    logic [BLK_W-1:0]  pos;

    logic [BLOCKS-1:0][BLK_W-1:0] ids_a  [CHIPS];
    logic [BLOCKS-1:0][SPD_W-1:0] spds_a [CHIPS];
    logic [BLOCKS-1:0]            vlds_a [CHIPS];
    logic [BLK_W-1:0] top_idx_a [CHIPS];
    logic [BLK_W-1:0] bot_idx_a [CHIPS];
    logic [BLK_W-1:0] hit_idx_a [CHIPS];
    logic [CHIPS-1:0] top_ok_a, bot_ok_a, hit_ok_a;

    logic             lop_en;
    list_op_e         lop_kind;
    logic [BLK_W-1:0] lop_idx;

    // One list and one searcher per chip; only the addressed chip is edited.
    for (genvar c = 0; c < CHIPS; c++) begin : g_chip
        logic edit_here;
        assign edit_here = lop_en && (q_chip == CHIP_W'(c));

        sra_chip_list #(.BLOCKS(BLOCKS), .BLK_W(BLK_W), .SPD_W(SPD_W)) u_list (
            .clk     (clk),
            .rst_n   (rst_n),
            .op_en   (edit_here),
            .op_kind (lop_kind),
            .op_idx  (lop_idx),
            .op_spd  (q_spd),
            .ids     (ids_a[c]),
            .spds    (spds_a[c]),
            .vlds    (vlds_a[c])
        );

        sra_rank_find #(.BLOCKS(BLOCKS), .BLK_W(BLK_W)) u_find (
            .ids     (ids_a[c]),
            .vlds    (vlds_a[c]),
            .key     (q_blk),
            .top_idx (top_idx_a[c]),
            .top_ok  (top_ok_a[c]),
            .bot_idx (bot_idx_a[c]),
            .bot_ok  (bot_ok_a[c]),
            .hit_idx (hit_idx_a[c]),
            .hit_ok  (hit_ok_a[c])
        );
    end

    logic [BLOCKS-1:0][BLK_W-1:0] sel_ids;
    logic [BLOCKS-1:0][SPD_W-1:0] sel_spds;
    logic [BLK_W-1:0] sel_top, sel_bot, sel_hit;
    logic             sel_top_ok, sel_bot_ok, sel_hit_ok;
    logic [BLK_W-1:0] nxt_pos;
    logic             can_step;
    logic             demote_ok;
    logic             grant_ok;
    logic [BLK_W-1:0] grant_idx;

    // Select the addressed chip's list and search results.
    always_comb begin
        sel_ids    = ids_a[q_chip];
        sel_spds   = spds_a[q_chip];
        sel_top    = top_idx_a[q_chip];
        sel_bot    = bot_idx_a[q_chip];
        sel_hit    = hit_idx_a[q_chip];
        sel_top_ok = top_ok_a[q_chip];
        sel_bot_ok = bot_ok_a[q_chip];
        sel_hit_ok = hit_ok_a[q_chip];
    end

    // Decisions: grant choice, demotion acceptance, and whether the entry sinks further.
    always_comb begin
        nxt_pos   = pos + 1'b1;
        can_step  = (pos != LAST) && (sel_spds[nxt_pos] >= sel_spds[pos]);
        demote_ok = sel_hit_ok && (q_spd < sel_spds[sel_hit]);
        grant_ok  = q_fast ? sel_top_ok : sel_bot_ok;
        grant_idx = q_fast ? sel_top : sel_bot;
    end

    // List edit issued in the current cycle.
    always_comb begin
        lop_en   = 1'b0;
        lop_kind = LOP_SETV;
        lop_idx  = sel_hit;
        case (state)
            ST_EXEC: begin
                case (q_op)
                    CMD_RETIRE: begin
                        lop_en   = sel_hit_ok;
                        lop_kind = LOP_CLRV;
                    end
                    CMD_RESTORE: begin
                        lop_en   = sel_hit_ok;
                        lop_kind = LOP_SETV;
                    end
                    CMD_DEMOTE: begin
                        lop_en   = demote_ok;
                        lop_kind = LOP_SPEED;
                    end
                    default: ;
                endcase
            end
            ST_SHIFT: begin
                lop_en   = can_step;
                lop_kind = LOP_SWAP;
                lop_idx  = pos;
            end
            default: ;
        endcase
    end

    // Busy whenever a command is in flight.
    always_comb begin
        busy = (state != ST_IDLE);
    end

    // Command controller: accept, execute, sink, respond.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            q_op      <= CMD_ALLOC;
            q_chip    <= '0;
            q_blk     <= '0;
            q_spd     <= '0;
            q_fast    <= 1'b0;
            pos       <= '0;
            rsp_valid <= 1'b0;
            rsp_block <= '0;
            rsp_none  <= 1'b0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (cmd_valid) begin
                        q_op   <= cmd_op_e'(cmd_op);
                        q_chip <= cmd_chip;
                        q_blk  <= cmd_block;
                        q_spd  <= cmd_speed;
                        q_fast <= (cmd_pending > PEND_W'(1));
                        state  <= ST_EXEC;
                    end
                end
                ST_EXEC: begin
                    case (q_op)
                        CMD_ALLOC: begin
                            rsp_valid <= 1'b1;
                            rsp_none  <= !grant_ok;
                            rsp_block <= grant_ok ? sel_ids[grant_idx] : '0;
                            state     <= ST_IDLE;
                        end
                        CMD_DEMOTE: begin
                            if (demote_ok) begin
                                pos   <= sel_hit;
                                state <= ST_SHIFT;
                            end else begin
                                rsp_valid <= 1'b1;
                                rsp_none  <= 1'b1;
                                rsp_block <= q_blk;
                                state     <= ST_IDLE;
                            end
                        end
                        default: begin
                            rsp_valid <= 1'b1;
                            rsp_none  <= !sel_hit_ok;
                            rsp_block <= q_blk;
                            state     <= ST_IDLE;
                        end
                    endcase
                end
                ST_SHIFT: begin
                    if (can_step) begin
                        pos <= nxt_pos;
                    end else begin
                        rsp_valid <= 1'b1;
                        rsp_none  <= 1'b0;
                        rsp_block <= q_blk;
                        state     <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/speed_rank_alloc_chk.sv
// Protocol and ordering checks for the speed-ranked allocator, attached by bind.
module speed_rank_alloc_chk #(
    parameter int CHIPS  = 4,
    parameter int BLOCKS = 8,
    parameter int SPD_W  = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         cmd_valid,
    input logic                         busy,
    input logic                         rsp_valid,
    input logic [BLOCKS-1:0][SPD_W-1:0] spds_a [CHIPS]
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy);

    // R3
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R3
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !busy);

    // R3
    fell_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rsp_valid);

    for (genvar c = 0; c < CHIPS; c++) begin : g_ord
        logic sorted;

        // Adjacent ranks must never increase in speed code.
        always_comb begin
            sorted = 1'b1;
            for (int j = 0; j + 1 < BLOCKS; j++) begin
                if (spds_a[c][j+1] > spds_a[c][j]) sorted = 1'b0;
            end
        end

        // R12
        order_sorted_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !busy |-> sorted);
    end
endmodule

bind speed_rank_alloc speed_rank_alloc_chk #(
    .CHIPS  (CHIPS),
    .BLOCKS (BLOCKS),
    .SPD_W  (SPD_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .spds_a    (spds_a)
);

// File: tb/speed_rank_alloc_tb.sv
`timescale 1ns/1ps
module speed_rank_alloc_tb;
    localparam int CHIPS  = 4;
    localparam int BLOCKS = 8;
    localparam int SPD_W  = 4;
    localparam int PEND_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = '0;
    logic [1:0] cmd_chip = '0;
    logic [2:0] cmd_block = '0;
    logic [SPD_W-1:0]  cmd_speed = '0;
    logic [PEND_W-1:0] cmd_pending = '0;
    logic       busy, rsp_valid, rsp_none;
    logic [2:0] rsp_block;

    speed_rank_alloc #(.CHIPS(CHIPS), .BLOCKS(BLOCKS), .SPD_W(SPD_W), .PEND_W(PEND_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chip(cmd_chip), .cmd_block(cmd_block), .cmd_speed(cmd_speed),
        .cmd_pending(cmd_pending), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_block(rsp_block), .rsp_none(rsp_none)
    );

    always #4 clk = ~clk;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    blk;
        bit    none;
        string req;
    } exp_t;
    exp_t sb[$];

    int m_id  [CHIPS][BLOCKS];
    int m_spd [CHIPS][BLOCKS];
    bit m_vld [CHIPS][BLOCKS];

    function automatic void chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endfunction

    function automatic int mfind(int c, int b);
        for (int j = 0; j < BLOCKS; j++) if (m_id[c][j] == b) return j;
        return -1;
    endfunction

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    // Monitor: compare each response against the oldest expected item.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                chk(0, "R2", "response without pending command", 1, 0);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(cyc == e.at, e.req, "response cycle", cyc, e.at);
                chk(rsp_none == e.none, e.req, "rsp_none", rsp_none, e.none);
                if (!e.none) chk(rsp_block == e.blk[2:0], e.req, "rsp_block", rsp_block, e.blk);
            end
        end
    end

    // Watchdog: a hung run is a failure and still reports.
    always @(posedge clk) begin
        if (cyc > 150000) begin
            chk(0, "watchdog", "run time", cyc, 150000);
            finish_run();
        end
    end

    // Driver: predict from the reference list, queue the expectation, drive one command.
    task automatic issue(int op, int c, int b, int spd, int pend, string req, bit intrude = 0);
        exp_t e;
        int   lat = 1;
        e.blk  = b;
        e.none = 0;
        e.req  = req;
        case (op)
            0: begin
                int f = -1;
                if (pend > 1) begin
                    for (int j = 0; j < BLOCKS; j++) if (m_vld[c][j] && f < 0) f = j;
                end else begin
                    for (int j = BLOCKS - 1; j >= 0; j--) if (m_vld[c][j] && f < 0) f = j;
                end
                if (f < 0) e.none = 1;
                else e.blk = m_id[c][f];
            end
            1: m_vld[c][mfind(c, b)] = 0;
            2: m_vld[c][mfind(c, b)] = 1;
            default: begin
                int p = mfind(c, b);
                if (spd < m_spd[c][p]) begin
                    int k = 0;
                    bit v = m_vld[c][p];
                    for (int j = p + 1; j < BLOCKS; j++) if (m_spd[c][j] >= spd) k++;
                    for (int j = p; j < p + k; j++) begin
                        m_id[c][j]  = m_id[c][j+1];
                        m_spd[c][j] = m_spd[c][j+1];
                        m_vld[c][j] = m_vld[c][j+1];
                    end
                    m_id[c][p+k]  = b;
                    m_spd[c][p+k] = spd;
                    m_vld[c][p+k] = v;
                    lat = k + 2;
                end else begin
                    e.none = 1;
                end
            end
        endcase
        e.at = cyc + 1 + lat;
        sb.push_back(e);
        cmd_valid   = 1'b1;
        cmd_op      = op[1:0];
        cmd_chip    = c[1:0];
        cmd_block   = b[2:0];
        cmd_speed   = spd[SPD_W-1:0];
        cmd_pending = pend[PEND_W-1:0];
        @(negedge clk);
        cmd_valid = 1'b0;
        if (intrude) begin
            // R2: a retire of chip 1 block 7 while busy must be dropped
            chk(busy == 1'b1, "R2", "busy during demotion", busy, 1);
            cmd_valid = 1'b1;
            cmd_op    = 2'b01;
            cmd_chip  = 2'd1;
            cmd_block = 3'd7;
            @(negedge clk);
            cmd_valid = 1'b0;
        end
        while (sb.size() != 0) @(negedge clk);
    endtask

    initial begin
        logic [15:0] lf = 16'hACE1;
        for (int c = 0; c < CHIPS; c++)
            for (int j = 0; j < BLOCKS; j++) begin
                m_id[c][j]  = j;
                m_spd[c][j] = (1 << SPD_W) - 1;
                m_vld[c][j] = 1;
            end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", rsp_valid, 0);

        issue(0, 0, 0, 0, 2, "R4");   // R1 R4: fastest is block 0
        issue(0, 0, 0, 0, 1, "R5");   // R1 R5: slowest is block 7
        issue(0, 0, 0, 0, 0, "R5");
        issue(1, 0, 0, 0, 0, "R7");
        issue(0, 0, 0, 0, 3, "R7");   // retired block 0 skipped
        issue(1, 0, 7, 0, 0, "R7");
        issue(0, 0, 0, 0, 1, "R7");   // retired block 7 skipped
        issue(2, 0, 0, 0, 0, "R8");
        issue(0, 0, 0, 0, 2, "R8");   // block 0 back at rank 0
        issue(2, 0, 7, 0, 0, "R8");
        for (int b = 0; b < BLOCKS; b++) issue(1, 2, b, 0, 0, "R7");
        issue(0, 2, 0, 0, 5, "R6");
        issue(0, 2, 0, 0, 0, "R6");
        issue(2, 2, 3, 0, 0, "R8");
        issue(0, 2, 0, 0, 0, "R8");
        issue(3, 0, 0, 5, 0, "R9", 1);
        issue(0, 1, 0, 0, 0, "R11");  // R2 R11: intruding retire was dropped
        issue(0, 0, 0, 0, 0, "R9");
        issue(3, 0, 1, 5, 0, "R9");   // stops behind equal code
        issue(3, 0, 3, 9, 0, "R9");   // stops ahead of lower codes
        issue(0, 0, 0, 0, 0, "R9");
        issue(3, 0, 3, 9, 0, "R10");
        issue(3, 0, 3, 12, 0, "R10");
        issue(0, 0, 0, 0, 2, "R10");
        issue(0, 3, 0, 0, 2, "R11");
        issue(0, 3, 0, 0, 0, "R11");

        for (int n = 0; n < 300; n++) begin
            int op, c, b, s, p;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            op = lf[1:0];
            c  = lf[3:2];
            b  = lf[6:4];
            s  = lf[10:7];
            p  = lf[12:11];
            case (op)
                0: issue(op, c, b, s, p, (p > 1) ? "R4" : "R5");
                1: issue(op, c, b, s, p, "R7");
                2: issue(op, c, b, s, p, "R8");
                default: issue(op, c, b, s, p, "R9");
            endcase
        end
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule